// File: doc/BRIEF.md
# Two-Image Dot-Matrix Scan Driver

This block feeds a 16x16 LED dot matrix built from a row decoder and a chain of serial-in, parallel-out shift registers with an output latch. For each row it shifts a column word onto a single serial data line with its own divided shift clock. It then pulses a latch strobe so that the new column word and the new row address reach the matrix in the same cycle. Rows advance on a fixed tick, nominally 1 ms, so one full scan of 16 rows takes 16 ticks.

A two-bit mode input selects what the matrix shows. The lamp-test mode lights every dot, and the blank modes turn every dot off. The image mode alternates between two built-in pictures, each held for a fixed number of row ticks (nominally 1000, or one second), and keeps looping without ever going dark. Both pictures are computed from the row index instead of being stored as a table. Row-tick length, image hold time, column count, row-address width and shift bit order are all parameters.

Top module: `dm_matrix_driver`

## Requirements
- R1: While reset is held, row_addr is all ones (the last row), and ser_data, shift_clk and latch_stb are 0.
- R2: out_en_n is 0 at all times.
- R3: For each row, shift_clk gives exactly COLS rising edges. Each high phase lasts exactly 2 clock cycles, and the low phase between two bits lasts 2 cycles. shift_clk is low whenever latch_stb is high.
- R4: ser_data changes only in cycles where shift_clk is low, so it is stable at every rising edge and throughout each high phase.
- R5: With MSB_FIRST=1, the first bit shifted for a row is column bit COLS-1. With MSB_FIRST=0, it is column bit 0.
- R6: latch_stb is a one-cycle pulse that rises in the cycle shift_clk falls after the last bit of a row. row_addr changes only in a cycle where latch_stb is high.
- R7: Each latch pulse advances row_addr by one, modulo 2**ROW_BITS, starting from row 0 after reset. Latch pulses are exactly ROW_TICKS clock cycles apart.
- R8: In mode 1 (lamp test), every latched column word is all ones.
- R9: In mode 0 and in mode 3 (blank), every latched column word is all zeros.
- R10: In mode 2 (image), let k be the count of rows loaded since the mode was entered, starting at 0. Row k shows image (k / ROWS_PER_GLYPH) mod 2. Image 0 for row r has all columns set in rows 0 and 2**ROW_BITS-1, and only columns 0 and COLS-1 set in the other rows. Image 1 for row r has columns (r mod COLS) and COLS-1-(r mod COLS) set.
- R11: The mode is sampled when a row's word is loaded. Leaving image mode and entering it again restarts from image 0 with k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0/3 blank, 1 lamp test, 2 alternating images |
| row_addr | output | ROW_BITS | Row address to the external decoder |
| ser_data | output | 1 | Serial column data |
| shift_clk | output | 1 | Shift clock of the register chain |
| latch_stb | output | 1 | Latch strobe of the register chain |
| out_en_n | output | 1 | Output enable, active low, held at 0 |

## Verification
The bench builds two instances with ROW_TICKS=70 and ROWS_PER_GLYPH=5. The first is MSB-first and the second is LSB-first, and the rest are defaults. A 70-cycle row leaves only a few idle cycles after the 65-cycle shift and latch sequence. This makes every row boundary, latch spacing and mode change visible within a few thousand cycles. The short image hold brings several image swaps and a re-entry into image mode within reach. A serial-register model in the bench then reconstructs each latched word and compares it with words computed from the row index, for both bit orders.

// File: rtl/dm_pkg.sv
package dm_pkg;

   typedef enum logic [1:0] {
      DM_BLANK     = 2'd0,
      DM_LAMP      = 2'd1,
      DM_GLYPH     = 2'd2,
      DM_BLANK_ALT = 2'd3
   } dm_mode_e;

endpackage

// File: rtl/dm_row_timer.sv
module dm_row_timer #(
   parameter int ROW_TICKS      = 50000,
   parameter int ROWS_PER_GLYPH = 1000,
   parameter int ROW_BITS       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                glyph_mode,
   output logic                start,
   output logic [ROW_BITS-1:0] row_idx,
   output logic                glyph_sel
);
   localparam int TW = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
   localparam int GW = (ROWS_PER_GLYPH > 1) ? $clog2(ROWS_PER_GLYPH) : 1;

   logic [TW-1:0] tick_q;
   logic [GW-1:0] hold_q;
   logic          end_of_row;

   assign end_of_row = (tick_q == TW'(ROW_TICKS - 1));
   assign start      = (tick_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q  <= '0;
         row_idx <= '0;
      end else if (end_of_row) begin
         tick_q  <= '0;
         row_idx <= row_idx + 1'b1;
      end else begin
         tick_q  <= tick_q + 1'b1;
      end
   end

   // image phase: counted in row loads, cleared by any non-image load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         glyph_sel <= 1'b0;
      end else if (start) begin
         if (!glyph_mode) begin
            hold_q    <= '0;
            glyph_sel <= 1'b0;
         end else if (hold_q == GW'(ROWS_PER_GLYPH - 1)) begin
            hold_q    <= '0;
            glyph_sel <= ~glyph_sel;
         end else begin
            hold_q <= hold_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dm_word_src.sv
module dm_word_src #(
   parameter int ROW_BITS = 4,
   parameter int COLS     = 16
) (
   input  dm_pkg::dm_mode_e    mode,
   input  logic                glyph_sel,
   input  logic [ROW_BITS-1:0] row,
   output logic [COLS-1:0]     word
);
   localparam int ROWS = 2 ** ROW_BITS;

   logic [COLS-1:0] img0, img1;

   always_comb begin
      int r, rm;
      r  = int'(row);
      rm = r % COLS;
      for (int c = 0; c < COLS; c++) begin
         img0[c] = (r == 0) || (r == ROWS - 1) || (c == 0) || (c == COLS - 1);
         img1[c] = (c == rm) || (c == COLS - 1 - rm);
      end
   end

   always_comb begin
      unique case (mode)
         dm_pkg::DM_LAMP:  word = '1;
         dm_pkg::DM_GLYPH: word = glyph_sel ? img1 : img0;
         default:          word = '0;
      endcase
   end

endmodule

// File: rtl/dm_serializer.sv
module dm_serializer #(
   parameter int COLS      = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [COLS-1:0] word,
   output logic            ser_data,
   output logic            shift_clk,
   output logic            latch_stb,
   output logic            fire
);
   localparam int BW = (COLS > 1) ? $clog2(COLS) : 1;

   logic            busy_q;
   logic [1:0]      ph_q;
   logic [BW-1:0]   bit_q;
   logic [COLS-1:0] sh_q, sh_next;
   logic            head;
   logic            last_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign head    = sh_q[COLS-1];
         assign sh_next = {sh_q[COLS-2:0], 1'b0};
      end else begin : g_lsb
         assign head    = sh_q[0];
         assign sh_next = {1'b0, sh_q[COLS-1:1]};
      end
   endgenerate

   assign last_bit = (bit_q == BW'(COLS - 1));
   assign fire     = busy_q && (ph_q == 2'd3) && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ph_q      <= '0;
         bit_q     <= '0;
         sh_q      <= '0;
         ser_data  <= 1'b0;
         shift_clk <= 1'b0;
         latch_stb <= 1'b0;
      end else begin
         latch_stb <= 1'b0;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            ph_q   <= '0;
            bit_q  <= '0;
            sh_q   <= word;
         end else if (busy_q) begin
            ph_q <= ph_q + 1'b1;
            unique case (ph_q)
               2'd0: ser_data  <= head;
               2'd1: shift_clk <= 1'b1;
               2'd2: shift_clk <= 1'b1;
               default: begin
                  shift_clk <= 1'b0;
                  sh_q      <= sh_next;
                  if (last_bit) begin
                     busy_q    <= 1'b0;
                     latch_stb <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/dm_matrix_driver.sv
module dm_matrix_driver #(
   parameter int ROW_BITS       = 4,
   parameter int COLS           = 16,
   parameter int ROW_TICKS      = 50000,
   parameter int ROWS_PER_GLYPH = 1000,
   parameter bit MSB_FIRST      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   output logic [ROW_BITS-1:0] row_addr,
   output logic                ser_data,
   output logic                shift_clk,
   output logic                latch_stb,
   output logic                out_en_n
);
   localparam int SHIFT_CYCLES = 4 * COLS + 2;

   generate
      if (ROW_BITS < 1) begin : g_bad_rows
         $fatal(1, "ROW_BITS must be at least 1");
      end
      if (COLS < 2) begin : g_bad_cols
         $fatal(1, "COLS must be at least 2");
      end
      if (ROW_TICKS < SHIFT_CYCLES) begin : g_bad_ticks
         $fatal(1, "ROW_TICKS too short for one column word");
      end
      if (ROWS_PER_GLYPH < 2) begin : g_bad_hold
         $fatal(1, "ROWS_PER_GLYPH must be at least 2");
      end
   endgenerate

   dm_pkg::dm_mode_e    mode_e;
   logic                start, glyph_sel, fire;
   logic [ROW_BITS-1:0] row_idx, pend_row_q;
   logic [COLS-1:0]     word;

   assign mode_e   = dm_pkg::dm_mode_e'(mode);
   assign out_en_n = 1'b0;

   dm_row_timer #(
      .ROW_TICKS     (ROW_TICKS),
      .ROWS_PER_GLYPH(ROWS_PER_GLYPH),
      .ROW_BITS      (ROW_BITS)
   ) u_tim (
      .clk       (clk),
      .rst_n     (rst_n),
      .glyph_mode(mode_e == dm_pkg::DM_GLYPH),
      .start     (start),
      .row_idx   (row_idx),
      .glyph_sel (glyph_sel)
   );

   dm_word_src #(
      .ROW_BITS(ROW_BITS),
      .COLS    (COLS)
   ) u_src (
      .mode     (mode_e),
      .glyph_sel(glyph_sel),
      .row      (row_idx),
      .word     (word)
   );

   dm_serializer #(
      .COLS     (COLS),
      .MSB_FIRST(MSB_FIRST)
   ) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .word     (word),
      .ser_data (ser_data),
      .shift_clk(shift_clk),
      .latch_stb(latch_stb),
      .fire     (fire)
   );

   // row shown on the decoder moves in the same cycle the strobe rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_row_q <= '0;
         row_addr   <= '1;
      end else begin
         if (start) pend_row_q <= row_idx;
         if (fire)  row_addr   <= pend_row_q;
      end
   end

endmodule

// File: rtl/dm_matrix_driver_chk.sv
module dm_matrix_driver_chk #(
   parameter int ROW_BITS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ROW_BITS-1:0] row_addr,
   input logic                ser_data,
   input logic                shift_clk,
   input logic                latch_stb,
   input logic                out_en_n
);

   a_r2_oe_active: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n == 1'b0);

   a_r3_high_two: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shift_clk) |=> shift_clk);

   a_r3_high_ends: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shift_clk) |-> ##2 !shift_clk);

   a_r3_low_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |-> !shift_clk);

   a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      shift_clk |-> $stable(ser_data));

   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |=> !latch_stb);

   a_r6_row_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_stb |-> $stable(row_addr));

   a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |-> row_addr == ROW_BITS'($past(row_addr) + 1'b1));

endmodule

bind dm_matrix_driver dm_matrix_driver_chk #(.ROW_BITS(ROW_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .row_addr (row_addr),
   .ser_data (ser_data),
   .shift_clk(shift_clk),
   .latch_stb(latch_stb),
   .out_en_n (out_en_n)
);

// File: tb/sim_dm_matrix_driver.sv
`timescale 1ns/1ps
module sim_dm_matrix_driver;
   localparam int RB   = 4;
   localparam int NC   = 16;
   localparam int NR   = 16;
   localparam int RT   = 70;
   localparam int HOLD = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'd2;
   always #10 clk = ~clk;

   logic [RB-1:0] row_w [2];
   logic          ds_w [2], sck_w [2], stb_w [2], oe_w [2];

   dm_matrix_driver #(.ROW_BITS(RB), .COLS(NC), .ROW_TICKS(RT),
      .ROWS_PER_GLYPH(HOLD), .MSB_FIRST(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .row_addr(row_w[0]),
      .ser_data(ds_w[0]), .shift_clk(sck_w[0]), .latch_stb(stb_w[0]),
      .out_en_n(oe_w[0]));

   dm_matrix_driver #(.ROW_BITS(RB), .COLS(NC), .ROW_TICKS(RT),
      .ROWS_PER_GLYPH(HOLD), .MSB_FIRST(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .row_addr(row_w[1]),
      .ser_data(ds_w[1]), .shift_clk(sck_w[1]), .latch_stb(stb_w[1]),
      .out_en_n(oe_w[1]));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NC-1:0] exp_word(input logic [1:0] m, input int k, input int r);
      logic [NC-1:0] w;
      int rm;
      rm = r % NC;
      w = '0;
      if (m == 2'd1) w = '1;
      else if (m == 2'd2) begin
         for (int c = 0; c < NC; c++) begin
            if (((k / HOLD) % 2) == 0)
               w[c] = (r == 0) || (r == NR - 1) || (c == 0) || (c == NC - 1);
            else
               w[c] = (c == rm) || (c == NC - 1 - rm);
         end
      end
      return w;
   endfunction

   // serial-register model and per-row checks, sampled at the falling edge
   logic [NC-1:0] sr [2];
   bit  p_sck [2], p_stb [2], p_ds [2];
   int  rises [2], hi_run [2], last_lat [2], prev_row [2], gk [2];
   int  cyc = 0;
   int  lat_n = 0;

   initial begin
      for (int d = 0; d < 2; d++) begin
         sr[d] = '0; p_sck[d] = 0; p_stb[d] = 0; p_ds[d] = 0;
         rises[d] = 0; hi_run[d] = 0; last_lat[d] = -1;
         prev_row[d] = NR - 1; gk[d] = 0;
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         for (int d = 0; d < 2; d++) begin
            if (sck_w[d]) begin
               check(ds_w[d] == p_ds[d], "R4 data moved while shift clock high", ds_w[d], p_ds[d]);
            end
            if (sck_w[d] && !p_sck[d]) begin
               if (d == 0) sr[d] = {sr[d][NC-2:0], ds_w[d]};
               else        sr[d] = {ds_w[d], sr[d][NC-1:1]};
               rises[d]++;
               hi_run[d] = 1;
            end else if (sck_w[d]) begin
               hi_run[d]++;
            end
            if (!sck_w[d] && p_sck[d] && d == 0)
               check(hi_run[d] == 2, "R3 shift clock high length", hi_run[d], 2);
            if (stb_w[d] && !p_stb[d]) begin
               logic [NC-1:0] ew;
               int r;
               r = int'(row_w[d]);
               check(rises[d] == NC, "R3 rising edges per row", rises[d], NC);
               check(r == (prev_row[d] + 1) % NR, "R7 row step", r, (prev_row[d] + 1) % NR);
               if (last_lat[d] >= 0)
                  check(cyc - last_lat[d] == RT, "R7 latch spacing", cyc - last_lat[d], RT);
               ew = exp_word(mode, gk[d], r);
               if (mode == 2'd1)      check(sr[d] == ew, "R8 lamp word", int'(sr[d]), int'(ew));
               else if (mode == 2'd2) check(sr[d] == ew, d == 0 ? "R10 R5 image word msb-first" : "R10 R5 image word lsb-first", int'(sr[d]), int'(ew));
               else                   check(sr[d] == ew, "R9 blank word", int'(sr[d]), int'(ew));
               gk[d] = (mode == 2'd2) ? gk[d] + 1 : 0;
               prev_row[d] = r;
               last_lat[d] = cyc;
               rises[d] = 0;
               if (d == 0) lat_n++;
            end
            p_sck[d] = sck_w[d];
            p_stb[d] = stb_w[d];
            p_ds[d]  = ds_w[d];
         end
      end
   end

   task automatic run_rows(input int n, input logic [1:0] m);
      for (int i = 0; i < n; i++) begin
         @(posedge stb_w[0]);
      end
      @(negedge clk);
      @(negedge clk);
      mode = m;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int d = 0; d < 2; d++) begin
         check(row_w[d] == '1, "R1 reset row", row_w[d], 15);
         check(ds_w[d] == 0 && sck_w[d] == 0 && stb_w[d] == 0, "R1 reset outputs",
               {ds_w[d], sck_w[d], stb_w[d]}, 0);
         check(oe_w[d] == 0, "R2 enable low in reset", oe_w[d], 0);
      end
      rst_n = 1'b1;
      run_rows(23, 2'd1);   // image mode across four swaps, then lamp test
      run_rows(4, 2'd0);    // lamp, then blank
      run_rows(4, 2'd3);    // blank, then alternate blank code
      run_rows(3, 2'd2);    // R11: image re-entry restarts at image 0
      run_rows(12, 2'd2);
      @(posedge stb_w[0]);
      @(negedge clk);
      check(oe_w[0] == 0 && oe_w[1] == 0, "R2 enable low while running", oe_w[0], 0);
      check(lat_n >= 46, "R7 latch count", lat_n, 46);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(negedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", lat_n, 46);
         finish_run();
      end
   end

endmodule